// File: doc/BRIEF.md
# Tagged Transmit Byte Queue

This block sits between a processor port and a serial transmitter. The processor pushes packet bytes into a queue one byte at a time, starting with the address byte. The transmitter pulls them out in the same order as it needs them. Each queued entry carries an end-of-packet tag next to its data byte, so the transmitter knows where to append the checksum and the closing flag.

Software marks the last byte of a packet by pulsing a control bit before it writes that byte. The control bit stays armed until the next accepted byte write. That byte takes the tag, and the bit then clears itself.

A two-bit occupancy field lets software pace its writes. The field is frozen for two bit periods after every access from either side. While it is frozen, software sees a stable value even when its bus cycles are much shorter than a bit period.

Top module: `txq_tagged_fifo`

## Requirements
- R1: After reset the occupancy field reads 00, and `ovf_flag`, `pop_underrun`, `eop_armed` and `pop_eop` read 0.
- R2: Bytes come out on `pop_data` in the order they were accepted, with the data unchanged. This holds when the storage pointers wrap around the 19-entry store. Popped data appears on the clock after `pop_req`.
- R3: A pulse on `eop_arm` sets `eop_armed` to 1. The next accepted write stores tag 1 with its byte, and `eop_armed` returns to 0 on the clock after that write. A byte written while the bit is not armed stores tag 0. The tag of a popped entry appears on `pop_eop` in the same cycle as its data.
- R4: Once the field has settled, `occ_status` shows the fill level: 00 when empty, 01 for 1 to 4 bytes, 10 for 5 to 18 bytes, and 11 when all 19 entries are full.
- R5: `occ_status` keeps its value in the cycle of any write or pop request. It then keeps its value until two `bit_tick` pulses have passed with no further access. It updates on the clock after the second pulse.
- R6: A write while 19 bytes are held is dropped. The stored bytes and `eop_armed` are left unchanged, and `ovf_flag` is set.
- R7: A pop while the queue is empty drives `pop_data` and `pop_eop` to 0. It also raises `pop_underrun` for exactly one clock.
- R8: Once set, `ovf_flag` stays 1 until reset, through later pops and writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| bit_tick | input | 1 | One-clock pulse per serial bit period |
| wr_req | input | 1 | Processor byte write strobe |
| wr_byte | input | 8 | Byte to queue |
| eop_arm | input | 1 | Arms the end-of-packet tag for the next accepted write |
| pop_req | input | 1 | Transmitter pop strobe |
| pop_data | output | 8 | Popped byte, valid the clock after `pop_req` |
| pop_eop | output | 1 | Tag of the popped byte |
| pop_underrun | output | 1 | One-clock pulse after a pop of an empty queue |
| ovf_flag | output | 1 | Sticky flag for a dropped write |
| eop_armed | output | 1 | Current state of the self-clearing tag bit |
| occ_status | output | 2 | Frozen occupancy code |

## Verification
The bench checks the status field at the 4/5 boundary and at full. A wrong encoding shows 01 or 10 at the wrong count. The bench also samples the field one clock after the first bit pulse that follows an access. A hold of a single bit period would already show the new value there.

Bytes are pushed through enough cycles to wrap the pointers, and one write is made on a full queue. A wrap fault scrambles the order of the bytes. A design that does not drop the extra write returns a twentieth byte or clobbers the head entry. The bench also checks that the dropped write leaves the armed tag in place, so the tag still lands on the next accepted byte.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic [1:0] {
    OCC_EMPTY = 2'b00,
    OCC_LOW   = 2'b01,
    OCC_HIGH  = 2'b10,
    OCC_FULL  = 2'b11
  } occ_e;

  typedef struct packed {
    logic       eop;
    logic [7:0] data;
  } entry_t;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DEPTH = 19,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_req,
  input  txq_pkg::entry_t wr_entry,
  input  logic            pop_req,
  output logic            wr_accept,
  output txq_pkg::entry_t pop_entry,
  output logic            underrun,
  output logic            overflow,
  output logic [CW-1:0]   fill
);
  import txq_pkg::*;

  entry_t        mem_q [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] fill_d;
  entry_t        pop_d;
  logic          und_d, ovf_d, is_empty, is_full, pop_ok;

  assign is_empty  = (fill == '0);
  assign is_full   = (fill == CW'(DEPTH));
  assign wr_accept = wr_req && !is_full;
  assign pop_ok    = pop_req && !is_empty;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (wr_accept) wptr_d = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    if (pop_ok)    rptr_d = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    fill_d = fill;
    if (wr_accept && !pop_ok)      fill_d = fill + 1'b1;
    else if (pop_ok && !wr_accept) fill_d = fill - 1'b1;
    pop_d = pop_entry;
    if (pop_req) pop_d = pop_ok ? mem_q[rptr_q] : '0;
    und_d = pop_req && is_empty;
    ovf_d = overflow || (wr_req && is_full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q    <= '0;
      rptr_q    <= '0;
      fill      <= '0;
      pop_entry <= '0;
      underrun  <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      wptr_q    <= wptr_d;
      rptr_q    <= rptr_d;
      fill      <= fill_d;
      pop_entry <= pop_d;
      underrun  <= und_d;
      overflow  <= ovf_d;
    end
  end

  // storage array: no reset, written only on an accepted write
  always_ff @(posedge clk) begin
    if (wr_accept) mem_q[wptr_q] <= wr_entry;
  end

  p_fill_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && is_full && !pop_req) |=> $stable(fill));
  p_underrun_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && is_empty) |=> (underrun && pop_entry == '0));
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

// File: rtl/txq_status_hold.sv
module txq_status_hold #(
  parameter int DEPTH   = 19,
  parameter int HI_MARK = 5,
  parameter int HOLD    = 2,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int HW = $clog2(HOLD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          access,
  input  logic [CW-1:0] fill,
  output logic [1:0]    status
);
  import txq_pkg::*;

  logic [HW-1:0] hold_q, hold_d;
  occ_e          live, stat_q, stat_d;

  always_comb begin
    if (fill == '0)                 live = OCC_EMPTY;
    else if (fill == CW'(DEPTH))    live = OCC_FULL;
    else if (fill >= CW'(HI_MARK))  live = OCC_HIGH;
    else                            live = OCC_LOW;
  end

  always_comb begin
    hold_d = hold_q;
    stat_d = stat_q;
    if (access)                 hold_d = HW'(HOLD);
    else if (hold_q != '0) begin
      if (bit_tick)             hold_d = hold_q - 1'b1;
    end else                    stat_d = live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      stat_q <= OCC_EMPTY;
    end else begin
      hold_q <= hold_d;
      stat_q <= stat_d;
    end
  end

  assign status = stat_q;

  p_status_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (access || hold_q != '0) |=> $stable(status));
  p_hold_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    access |=> (hold_q == HW'(HOLD)));
endmodule

// File: rtl/txq_tagged_fifo.sv
module txq_tagged_fifo #(
  parameter int DEPTH   = 19,
  parameter int HI_MARK = 5,
  parameter int HOLD    = 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       wr_req,
  input  logic [7:0] wr_byte,
  input  logic       eop_arm,
  input  logic       pop_req,
  output logic [7:0] pop_data,
  output logic       pop_eop,
  output logic       pop_underrun,
  output logic       ovf_flag,
  output logic       eop_armed,
  output logic [1:0] occ_status
);
  import txq_pkg::*;

  logic [1:0]    rst_sync_q;
  logic          rst_n_i;
  logic          arm_q, arm_d, wr_accept;
  logic [CW-1:0] fill;
  entry_t        wr_entry, pop_entry;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  always_comb begin
    arm_d = arm_q;
    if (wr_accept) arm_d = 1'b0;
    if (eop_arm)   arm_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) arm_q <= 1'b0;
    else          arm_q <= arm_d;
  end

  assign wr_entry = '{eop: arm_q, data: wr_byte};

  txq_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .wr_req   (wr_req),
    .wr_entry (wr_entry),
    .pop_req  (pop_req),
    .wr_accept(wr_accept),
    .pop_entry(pop_entry),
    .underrun (pop_underrun),
    .overflow (ovf_flag),
    .fill     (fill)
  );

  txq_status_hold #(.DEPTH(DEPTH), .HI_MARK(HI_MARK), .HOLD(HOLD)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .bit_tick(bit_tick),
    .access  (wr_req || pop_req),
    .fill    (fill),
    .status  (occ_status)
  );

  assign pop_data  = pop_entry.data;
  assign pop_eop   = pop_entry.eop;
  assign eop_armed = arm_q;

  p_arm_consumed_r3: assert property (@(posedge clk) disable iff (!rst_n_i)
    (wr_accept && !eop_arm) |=> !eop_armed);
  p_arm_set_r3: assert property (@(posedge clk) disable iff (!rst_n_i)
    eop_arm |=> eop_armed);
  p_arm_kept_on_drop_r6: assert property (@(posedge clk) disable iff (!rst_n_i)
    (eop_armed && wr_req && !wr_accept) |=> eop_armed);
endmodule

// File: tb/sim_txq_tagged_fifo.sv
module sim_txq_tagged_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       wr_req = 1'b0;
  logic [7:0] wr_byte = '0;
  logic       eop_arm = 1'b0;
  logic       pop_req = 1'b0;
  logic [7:0] pop_data;
  logic       pop_eop, pop_underrun, ovf_flag, eop_armed;
  logic [1:0] occ_status;
  int checks = 0;
  int errors = 0;
  int tick_cnt = 0;

  txq_tagged_fifo u0 (.*);

  always #4 clk = ~clk;

  // bit pulse on every fourth clock, changed at the falling edge
  always @(negedge clk) begin
    tick_cnt = (tick_cnt + 1) % 4;
    bit_tick = (tick_cnt == 3);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); wr_req = 1'b1; wr_byte = b;
    @(negedge clk); wr_req = 1'b0;
  endtask

  task automatic arm();
    @(negedge clk); eop_arm = 1'b1;
    @(negedge clk); eop_arm = 1'b0;
  endtask

  task automatic pop_chk(input string req, input int d, input int t);
    @(negedge clk); pop_req = 1'b1;
    @(negedge clk); pop_req = 1'b0;
    chk(req, pop_data, d);
    chk(req, pop_eop, t);
  endtask

  task automatic settle();
    repeat (16) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 status", occ_status, 0);
    chk("R1 ovf", ovf_flag, 0);
    chk("R1 underrun", pop_underrun, 0);
    chk("R1 armed", eop_armed, 0);
    chk("R1 pop_eop", pop_eop, 0);
  endtask

  task automatic t_underrun();
    @(negedge clk); pop_req = 1'b1;
    @(negedge clk); pop_req = 1'b0;
    chk("R7 data", pop_data, 0);
    chk("R7 eop", pop_eop, 0);
    chk("R7 pulse", pop_underrun, 1);
    @(negedge clk);
    chk("R7 pulse width", pop_underrun, 0);
  endtask

  task automatic t_tag_order();
    arm();
    chk("R3 armed", eop_armed, 1);
    push(8'hA1);
    chk("R3 self clear", eop_armed, 0);
    push(8'hB2);
    arm();
    push(8'hC3);
    pop_chk("R2 R3 first", 8'hA1, 1);
    pop_chk("R2 R3 second", 8'hB2, 0);
    pop_chk("R2 R3 third", 8'hC3, 1);
    settle();
    chk("R4 empty", occ_status, 0);
  endtask

  task automatic t_levels_hold();
    for (int i = 0; i < 4; i++) push(8'h10 + 8'(i));
    settle();
    chk("R4 four bytes", occ_status, 1);
    push(8'h14);
    chk("R5 frozen at write", occ_status, 1);
    do @(negedge clk); while (!bit_tick);
    @(negedge clk);
    @(negedge clk);
    chk("R5 frozen after one tick", occ_status, 1);
    settle();
    chk("R4 five bytes", occ_status, 2);
    pop_chk("R2 head", 8'h10, 0);
    chk("R5 frozen at pop", occ_status, 2);
    settle();
    chk("R4 back to four", occ_status, 1);
  endtask

  task automatic t_full_overflow();
    // queue holds 11..14; fill to 19 so pointers wrap
    for (int i = 0; i < 15; i++) push(8'h20 + 8'(i));
    settle();
    chk("R4 eighteen+1 full", occ_status, 3);
    chk("R6 no ovf yet", ovf_flag, 0);
    arm();
    push(8'hEE);
    chk("R6 ovf set", ovf_flag, 1);
    chk("R6 armed kept", eop_armed, 1);
    for (int i = 0; i < 4; i++) pop_chk("R2 wrap old", 8'h11 + 8'(i), 0);
    for (int i = 0; i < 15; i++) pop_chk("R2 wrap new", 8'h20 + 8'(i), 0);
    t_underrun();
    chk("R8 ovf sticky", ovf_flag, 1);
    push(8'h5A);
    pop_chk("R3 tag after drop", 8'h5A, 1);
    chk("R8 ovf still", ovf_flag, 1);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_underrun();
    t_tag_order();
    t_levels_hold();
    t_full_overflow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule